// File: doc/BRIEF.md
# Floating-point control and status register

This block holds the 32-bit control and status word of a floating-point unit, together with the update and trap logic that surrounds it. Software writes it through a control-register write port and reads it back through a control-register read port. Only control register number 31 is implemented, and every other number reads as zero. After each arithmetic operation, the arithmetic unit presents six exception cause bits. It can also present a condition-code write, which a compare operation produces.

The block rewrites the cause field on every operation and accumulates the sticky flags. It tells the datapath in the same cycle whether the operation may commit its result. When a cause bit meets its enable, it raises a registered one-cycle trap pulse. The same trap check runs after a software write, so restoring a saved word that has a pending enabled cause traps at once.

Word layout:
- bits 1:0: rounding mode (0 = nearest, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity).
- bits 6:2: flags, in the order inexact, underflow, overflow, divide-by-zero, invalid.
- bits 11:7: enables, in the same order.
- bits 17:12: causes, in the same order, plus bit 17 for unimplemented operation.
- bit 23: condition code 0.
- bits 31:25: condition codes 1 to 7.
- bits 24 and 22:18: reserved.

Top module: `fp_ctl_status`

## Requirements
- R1: Reset clears the whole status word to zero and holds `trap_o` low.
- R2: A software write with `sw_wr_sel` = 31 stores `sw_wr_data` under mask 0xFE83FFFF, including the cause field 17:12. Reserved bits 24 and 22:18 keep their previous value, which is zero. A write with any other number changes nothing.
- R3: `rd_data` returns the status word when `rd_sel` = 31, and zero for any other number.
- R4: An accepted operation (`op_valid` with no software write) replaces cause bits 17:12 with `op_cause[5:0]`, bit for bit.
- R5: An accepted operation ORs `op_cause[4:0]` into flag bits 6:2. Flags are never cleared except by a software write.
- R6: `trap_o` is high for the cycle after an accepted operation or a software write when the resulting word has cause bit 17 set, or has a cause bit 12+i set together with enable bit 7+i (i = 0..4). Otherwise it is low.
- R7: `commit_ok` is high in the same cycle exactly when an operation is accepted and it does not trap under the current enables.
- R8: A committing operation with `op_cc_wr` writes `op_cc_val` into condition code `op_cc_idx` (index 0 at bit 23, index k at bit 24+k). A trapping operation leaves every condition code unchanged.
- R9: `round_mode` reflects bits 1:0 of the status word.
- R10: When `sw_wr_en` and `op_valid` are both high, the software write is applied, the operation is ignored, and `commit_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software control-register write strobe |
| sw_wr_sel | input | 5 | Control register number written |
| sw_wr_data | input | 32 | Write data |
| rd_sel | input | 5 | Control register number read |
| rd_data | output | 32 | Read data |
| op_valid | input | 1 | Arithmetic operation completes this cycle |
| op_cause | input | 6 | Operation cause bits (unimpl, invalid, div0, overflow, underflow, inexact) |
| op_cc_wr | input | 1 | Operation writes a condition code |
| op_cc_idx | input | 3 | Condition code index |
| op_cc_val | input | 1 | Condition code value |
| commit_ok | output | 1 | Datapath may write the result |
| trap_o | output | 1 | Registered trap pulse |
| round_mode | output | 2 | Current rounding mode |

## Verification
The bench restores a word that carries an enabled cause and expects a trap on the next cycle. A design that checked only after arithmetic would miss it. The bench uses the unimplemented cause with all enables clear to catch a design that wrongly requires an enable. It also follows a trapping compare with a read of the condition codes, which exposes a design that updates the code before the trap decision. It sends a zero-cause operation after flags have been set: a design that treats the flags like the causes clears them, and one that treats the causes like the flags keeps stale causes. Finally, it writes the reserved positions and non-31 register numbers, which shows up any bit leaking through the mask.

// File: rtl/fp_ctl_status.sv
module fp_ctl_status #(
  parameter int SEL_W      = 5,
  parameter int STATUS_SEL = 31,
  parameter int CC_IW      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [SEL_W-1:0] sw_wr_sel,
  input  logic [31:0]      sw_wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [31:0]      rd_data,
  input  logic             op_valid,
  input  logic [5:0]       op_cause,
  input  logic             op_cc_wr,
  input  logic [CC_IW-1:0] op_cc_idx,
  input  logic             op_cc_val,
  output logic             commit_ok,
  output logic             trap_o,
  output logic [1:0]       round_mode
);
  localparam logic [31:0] WR_MASK = 32'hFE83_FFFF;
  localparam logic [SEL_W-1:0] SEL = SEL_W'(STATUS_SEL);

  logic [31:0] csr_q, after_sw, after_op, csr_d;
  logic        op_traps, trap_q;
  logic [4:0]  cc_pos;

  function automatic logic pending(input logic [31:0] w);
    return w[17] | (|(w[16:12] & w[11:7]));
  endfunction

  assign after_sw = (sw_wr_sel == SEL) ? ((sw_wr_data & WR_MASK) | (csr_q & ~WR_MASK)) : csr_q;
  assign op_traps = op_cause[5] | (|(op_cause[4:0] & csr_q[11:7]));
  assign cc_pos   = (op_cc_idx == '0) ? 5'd23 : 5'd24 + 5'(op_cc_idx);

  always_comb begin
    after_op        = csr_q;
    after_op[17:12] = op_cause;
    after_op[6:2]   = csr_q[6:2] | op_cause[4:0];
    if (op_cc_wr && !op_traps) after_op[cc_pos] = op_cc_val;
  end

  assign csr_d = sw_wr_en ? after_sw : (op_valid ? after_op : csr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      csr_q  <= csr_d;
      trap_q <= (sw_wr_en | op_valid) & pending(csr_d);
    end
  end

  assign commit_ok  = op_valid & ~sw_wr_en & ~op_traps;
  assign trap_o     = trap_q;
  assign rd_data    = (rd_sel == SEL) ? csr_q : 32'h0;
  assign round_mode = csr_q[1:0];
endmodule

// File: rtl/fp_ctl_status_chk.sv
module fp_ctl_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr_en,
  input logic [4:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic        op_valid,
  input logic [5:0]  op_cause,
  input logic        commit_ok,
  input logic        trap_o,
  input logic [31:0] csr
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr & 32'h017C_0000) == 32'h0);
  assert_read_other_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel != 5'd31 |-> rd_data == 32'h0);
  assert_cause_replace_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !sw_wr_en |=> csr[17:12] == $past(op_cause));
  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> (csr[6:2] & $past(csr[6:2])) == $past(csr[6:2]));
  assert_unimpl_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !sw_wr_en && op_cause[5] |=> trap_o);
  assert_idle_no_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !sw_wr_en |=> !trap_o);
  assert_commit_needs_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> op_valid);
  assert_trap_keeps_cc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !sw_wr_en && !commit_ok |=> {csr[31:25], csr[23]} == $past({csr[31:25], csr[23]}));
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |-> !commit_ok);
endmodule

bind fp_ctl_status fp_ctl_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .rd_sel(rd_sel), .rd_data(rd_data),
  .op_valid(op_valid), .op_cause(op_cause), .commit_ok(commit_ok), .trap_o(trap_o),
  .csr(csr_q)
);

// File: tb/test_fp_ctl_status.sv
`timescale 1ns/100ps
module test_fp_ctl_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_wr_en = 0, op_valid = 0, op_cc_wr = 0, op_cc_val = 0;
  logic [4:0] sw_wr_sel = 0, rd_sel = 0;
  logic [31:0] sw_wr_data = 0, rd_data;
  logic [5:0] op_cause = 0;
  logic [2:0] op_cc_idx = 0;
  logic commit_ok, trap_o;
  logic [1:0] round_mode;
  int checks = 0, bad = 0;
  logic [31:0] m_csr = 0;
  logic exp_trap = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_ctl_status i_fp_ctl_status (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic op_trap(input logic [31:0] c, input logic [5:0] cause);
    return cause[5] | (|(cause[4:0] & c[11:7]));
  endfunction

  function automatic logic [31:0] next_word(input logic [31:0] c);
    logic [31:0] n = c;
    int pos;
    if (sw_wr_en) begin
      if (sw_wr_sel == 5'd31) n = (sw_wr_data & 32'hFE83_FFFF) | (c & 32'h017C_0000);
    end else if (op_valid) begin
      n[17:12] = op_cause;
      n[6:2] = c[6:2] | op_cause[4:0];
      pos = (op_cc_idx == 0) ? 23 : 24 + int'(op_cc_idx);
      if (op_cc_wr && !op_trap(c, op_cause)) n[pos] = op_cc_val;
    end
    return n;
  endfunction

  task automatic step(input logic we, input logic [4:0] ws, input logic [31:0] wd,
                      input logic ov, input logic [5:0] oc, input logic cw,
                      input logic [2:0] ci, input logic cv, input logic [4:0] rs);
    logic [31:0] n;
    @(negedge clk);
    chk("R6 trap", {31'b0, trap_o}, {31'b0, exp_trap});
    sw_wr_en = we; sw_wr_sel = ws; sw_wr_data = wd; op_valid = ov; op_cause = oc;
    op_cc_wr = cw; op_cc_idx = ci; op_cc_val = cv; rd_sel = rs;
    #1;
    chk("R3 read", rd_data, (rs == 5'd31) ? m_csr : 32'h0);
    chk("R7 commit", {31'b0, commit_ok}, {31'b0, ov & ~we & ~op_trap(m_csr, oc)});
    chk("R9 round", {30'b0, round_mode}, {30'b0, m_csr[1:0]});
    n = next_word(m_csr);
    exp_trap = (we | ov) & (n[17] | (|(n[16:12] & n[11:7])));
    @(posedge clk);
    m_csr = n;
  endtask

  task automatic peek(input string tag, input logic [31:0] exp);
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd31);
    @(negedge clk); rd_sel = 5'd31; #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rd_sel = 5'd31; #1;
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset trap", {31'b0, trap_o}, 32'h0);
    rst_n = 1'b1;

    step(1, 5'd31, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 5'd31);
    peek("R2 masked write", 32'hFE83_FFFF);
    step(1, 5'd31, 32'h0000_0003, 0, 0, 0, 0, 0, 5'd31);
    step(1, 5'd7, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 5'd31);
    peek("R2 other number ignored", 32'h0000_0003);
    step(0, 0, 0, 1, 6'b000001, 0, 0, 0, 5'd0);
    peek("R4 R5 inexact cause and flag", 32'h0000_1007);
    step(0, 0, 0, 1, 6'b000000, 0, 0, 0, 5'd0);
    peek("R5 flag sticky cause cleared", 32'h0000_0007);
    step(1, 5'd31, 32'h0000_0207, 0, 0, 0, 0, 0, 5'd31);
    step(0, 0, 0, 1, 6'b000100, 1, 3'd3, 1, 5'd31);
    peek("R8 trapping op keeps cc", 32'h0000_4217);
    step(1, 5'd31, 32'h0000_4200, 0, 0, 0, 0, 0, 5'd31);
    step(1, 5'd31, 32'h0000_0000, 0, 0, 0, 0, 0, 5'd31);
    step(0, 0, 0, 1, 6'b000000, 1, 3'd0, 1, 5'd31);
    step(0, 0, 0, 1, 6'b000000, 1, 3'd7, 1, 5'd31);
    peek("R8 cc0 bit23 cc7 bit31", 32'h8080_0000);
    step(1, 5'd31, 32'h0000_0001, 1, 6'b010000, 1, 3'd1, 1, 5'd31);
    peek("R10 write wins", 32'h0000_0001);
    step(0, 0, 0, 1, 6'b100000, 0, 0, 0, 5'd31);
    peek("R6 unimplemented traps", 32'h0002_0001);

    for (int i = 0; i < 3000; i++) begin
      logic we, ov;
      logic [31:0] wd;
      we = ($urandom % 8) == 0;
      ov = ($urandom % 2) == 0;
      wd = $urandom;
      if ($urandom % 2) wd[11:7] = 5'b0;
      step(we, ($urandom % 4 == 0) ? 5'($urandom) : 5'd31, wd, ov,
           ($urandom % 3 == 0) ? 6'($urandom) & 6'h1F : 6'(($urandom % 8 == 0) ? 6'h20 : 6'h0),
           1'($urandom), 3'($urandom), 1'($urandom),
           ($urandom % 4 == 0) ? 5'($urandom) : 5'd31);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd31);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule